// File: doc/BRIEF.md
# Single-Precision Round-and-Pack Unit

This unit is the final stage of a floating-point datapath. An adder or multiplier upstream delivers an unpacked result: a sign, a biased 8-bit exponent, a significand that carries the hidden leading one plus one extra bit above it, and three low-order bits (guard, round, sticky). The unit turns that into a 32-bit IEEE 754 single-precision word.

In order, it does four things. First, it folds a one-position carry-out back into place. Second, it rounds to nearest with ties going to even. Third, it renormalizes when rounding ripples out of the significand. Fourth, it turns the result into infinity on exponent overflow, or into zero when there is no leading one. A separate invalid flag overrides all of this and produces a canonical quiet NaN.

The result is registered once, on a clock enable. It comes with two flags: one for overflow and one for a discarded nonzero bit.

Top module: `rp_round_pack`

## Requirements
- R1: When `in_valid` is high at a clock edge, the result of that input appears on the outputs after that edge and `out_valid` is high. When `in_valid` is low, `out_valid` falls and `out_word`, `out_ovf` and `out_inexact` keep their previous values.
- R2: The output word holds the sign in bit 31, the biased exponent in bits 30:23 and the fraction in bits 22:0. The fraction is the rounded significand with its hidden leading one removed.
- R3: With `in_sig[24]` clear, the significand `in_sig[23:0]` is rounded using `in_grs` (bit 2 guard, bit 1 round, bit 0 sticky). If `in_grs` is below 3'b100 the significand is truncated. If it is above 3'b100 the significand is incremented by one.
- R4: When the discarded bits are exactly half an LSB (guard 1, round 0, sticky 0), the significand is incremented only if its LSB is 1.
- R5: When `in_sig[24]` and `in_sig[23]` are both 0, or when `in_sig[24]` is 0 and `in_exp` is 0, the output is a signed zero: sign kept, exponent and fraction fields 0. `out_inexact` is set if any bit of `in_sig` or `in_grs` is nonzero.
- R6: When the final exponent reaches 255 or more, the output is infinity with the input sign (exponent field all ones, fraction 0). Both `out_ovf` and `out_inexact` are set.
- R7: When `in_invalid` is high, the output word is 0x7FC00000 and both flags are 0, whatever the other inputs are.
- R8: For a finite nonzero result, `out_inexact` is set exactly when any bit dropped by normalization or rounding is nonzero. `out_ovf` is 0.
- R9: When `in_sig[24]` is set, the significand is shifted right by one before rounding and the exponent is increased by one. The bit shifted out becomes the new guard bit, the old guard becomes round, and round OR sticky becomes the new sticky.
- R10: When rounding carries out of the 24-bit significand, the exponent is increased by one more and the fraction field becomes 0.
- R11: While `rst_n` is low, `out_valid`, `out_word`, `out_ovf` and `out_inexact` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture enable for the input result |
| in_invalid | input | 1 | Invalid operation; forces quiet NaN |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | 8 | Biased exponent |
| in_sig | input | 25 | Significand: bit 24 carry-out, bit 23 hidden one, bits 22:0 fraction |
| in_grs | input | 3 | Guard, round, sticky (bits 2, 1, 0) |
| out_valid | output | 1 | Output word holds a fresh result |
| out_word | output | 32 | Packed single-precision result |
| out_ovf | output | 1 | Exponent overflow, result is infinity |
| out_inexact | output | 1 | A nonzero bit was discarded |

## Verification
A wrong rounding increment or a misplaced sticky merge shows up as a fraction off by one LSB in the very next output word. A missed renormalization after a carry shows up as an exponent off by one at the same point. Because every result is registered exactly once, any fault reaches the ports one cycle after the input that triggers it.

The sweep therefore walks the guard, round and sticky codes together with the low fraction bits, an all-ones fraction, both carry and hidden states, and exponents near 0 and near 255. This exercises each rounding branch, each kind of carry and each exponent boundary, and the result of each vector is compared in the following cycle.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [1:0] {
    RK_FINITE = 2'd0,
    RK_ZERO   = 2'd1,
    RK_INF    = 2'd2,
    RK_NAN    = 2'd3
  } rp_kind_e;
endpackage

// File: rtl/rp_prenorm.sv
module rp_prenorm #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W+1:0] sig_i,
  input  logic [2:0]        grs_i,
  output logic [EXP_W:0]    exp_o,
  output logic [FRAC_W:0]   mant_o,
  output logic [2:0]        grs_o,
  output logic              zero_o
);
  logic carry;

  assign carry = sig_i[FRAC_W+1];

  always_comb begin
    if (carry) begin
      // fold the carry-out down; dropped LSB becomes guard, sticky absorbs the rest
      mant_o = sig_i[FRAC_W+1:1];
      grs_o  = {sig_i[0], grs_i[2], grs_i[1] | grs_i[0]};
      exp_o  = {1'b0, exp_i} + 1'b1;
    end else begin
      mant_o = sig_i[FRAC_W:0];
      grs_o  = grs_i;
      exp_o  = {1'b0, exp_i};
    end
  end

  assign zero_o = !carry && (!sig_i[FRAC_W] || (exp_i == '0));
endmodule

// File: rtl/rp_rounder.sv
module rp_rounder #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W:0]    exp_i,
  input  logic [FRAC_W:0]   mant_i,
  input  logic [2:0]        grs_i,
  output logic [EXP_W+1:0]  exp_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              inexact_o
);
  logic              bump;
  logic [FRAC_W+1:0] sum;

  assign bump      = grs_i[2] & (grs_i[1] | grs_i[0] | mant_i[0]);
  assign sum       = {1'b0, mant_i} + {{(FRAC_W+1){1'b0}}, bump};
  assign inexact_o = |grs_i;

  always_comb begin
    if (sum[FRAC_W+1]) begin
      frac_o = sum[FRAC_W:1];
      exp_o  = {1'b0, exp_i} + 1'b1;
    end else begin
      frac_o = sum[FRAC_W-1:0];
      exp_o  = {1'b0, exp_i};
    end
  end
endmodule

// File: rtl/rp_packer.sv
module rp_packer #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  rp_pkg::rp_kind_e     kind_i,
  input  logic                 sign_i,
  input  logic [EXP_W-1:0]     exp_i,
  input  logic [FRAC_W-1:0]    frac_i,
  output logic [EXP_W+FRAC_W:0] word_o
);
  import rp_pkg::*;

  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  always_comb begin
    unique case (kind_i)
      RK_ZERO:  word_o = {sign_i, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
      RK_INF:   word_o = {sign_i, EXP_ONES, {FRAC_W{1'b0}}};
      RK_NAN:   word_o = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};
      default:  word_o = {sign_i, exp_i, frac_i};
    endcase
  end
endmodule

// File: rtl/rp_round_pack.sv
module rp_round_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_invalid,
  input  logic                  in_sign,
  input  logic [EXP_W-1:0]      in_exp,
  input  logic [FRAC_W+1:0]     in_sig,
  input  logic [2:0]            in_grs,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] out_word,
  output logic                  out_ovf,
  output logic                  out_inexact
);
  import rp_pkg::*;

  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam logic [EXP_W+1:0] EXP_LIMIT = {2'b00, {EXP_W{1'b1}}};

  logic [EXP_W:0]    n_exp;
  logic [FRAC_W:0]   n_mant;
  logic [2:0]        n_grs;
  logic              n_zero;
  logic [EXP_W+1:0]  r_exp;
  logic [FRAC_W-1:0] r_frac;
  logic              r_inexact;
  rp_kind_e          kind;
  logic [WORD_W-1:0] word_nx;
  logic              ovf_nx;
  logic              inexact_nx;

  rp_prenorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .exp_i  (in_exp),
    .sig_i  (in_sig),
    .grs_i  (in_grs),
    .exp_o  (n_exp),
    .mant_o (n_mant),
    .grs_o  (n_grs),
    .zero_o (n_zero)
  );

  rp_rounder #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rnd (
    .exp_i     (n_exp),
    .mant_i    (n_mant),
    .grs_i     (n_grs),
    .exp_o     (r_exp),
    .frac_o    (r_frac),
    .inexact_o (r_inexact)
  );

  always_comb begin
    if (in_invalid) begin
      kind       = RK_NAN;
      ovf_nx     = 1'b0;
      inexact_nx = 1'b0;
    end else if (n_zero) begin
      kind       = RK_ZERO;
      ovf_nx     = 1'b0;
      inexact_nx = (|in_sig) | (|in_grs);
    end else if (r_exp >= EXP_LIMIT) begin
      kind       = RK_INF;
      ovf_nx     = 1'b1;
      inexact_nx = 1'b1;
    end else begin
      kind       = RK_FINITE;
      ovf_nx     = 1'b0;
      inexact_nx = r_inexact;
    end
  end

  rp_packer #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .kind_i (kind),
    .sign_i (in_sign),
    .exp_i  (r_exp[EXP_W-1:0]),
    .frac_i (r_frac),
    .word_o (word_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word    <= '0;
      out_ovf     <= 1'b0;
      out_inexact <= 1'b0;
    end else if (in_valid) begin
      out_word    <= word_nx;
      out_ovf     <= ovf_nx;
      out_inexact <= inexact_nx;
    end
  end
endmodule

// File: rtl/rp_round_pack_chk.sv
module rp_round_pack_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_invalid,
  input logic [EXP_W-1:0]      in_exp,
  input logic [FRAC_W+1:0]     in_sig,
  input logic [2:0]            in_grs,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] out_word,
  input logic                  out_ovf,
  input logic                  out_inexact
);
  localparam logic [EXP_W+FRAC_W:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word) && $stable(out_ovf) && $stable(out_inexact));

  a_r7_nan: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_invalid |=> out_word == QNAN && !out_ovf && !out_inexact);

  a_r6_inf_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |-> out_word[EXP_W+FRAC_W-1:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}} && out_inexact);

  a_r5_no_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
    out_word[EXP_W+FRAC_W-1:FRAC_W] == '0 |-> out_word[FRAC_W-1:0] == '0);

  a_r8_exact: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_invalid && in_grs == 3'b000 && !in_sig[FRAC_W+1]
      && in_sig[FRAC_W] && in_exp != '0 |=> !out_inexact || out_ovf);
endmodule

bind rp_round_pack rp_round_pack_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_invalid  (in_invalid),
  .in_exp      (in_exp),
  .in_sig      (in_sig),
  .in_grs      (in_grs),
  .out_valid   (out_valid),
  .out_word    (out_word),
  .out_ovf     (out_ovf),
  .out_inexact (out_inexact)
);

// File: tb/sim_rp_round_pack.sv
module sim_rp_round_pack;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_invalid;
  logic        in_sign;
  logic [7:0]  in_exp;
  logic [24:0] in_sig;
  logic [2:0]  in_grs;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_ovf;
  logic        out_inexact;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  rp_round_pack u0 (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_invalid (in_invalid),
    .in_sign (in_sign), .in_exp (in_exp), .in_sig (in_sig), .in_grs (in_grs),
    .out_valid (out_valid), .out_word (out_word), .out_ovf (out_ovf),
    .out_inexact (out_inexact)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // reference computed from the requirements with integer arithmetic
  task automatic model(input logic s, input logic [7:0] e, input logic [24:0] sig,
                       input logic [2:0] grs, input logic inv,
                       output logic [31:0] w, output logic ov, output logic ix,
                       output string tag);
    longint full, q, rem, half, ee;
    tag = "";
    if (inv) begin
      w = 32'h7FC00000; ov = 0; ix = 0; tag = "R7";
    end else if (!sig[24] && (!sig[23] || e == 0)) begin
      w = {s, 31'b0}; ov = 0; ix = (sig != 0) || (grs != 0); tag = "R5";
    end else begin
      full = {35'b0, sig, grs};
      if (sig[24]) begin
        q = full >> 4; rem = full & 15; half = 8; ee = e + 1; tag = "R9";
      end else begin
        q = full >> 3; rem = full & 7; half = 4; ee = e; tag = "R3";
      end
      if (rem == half) tag = {tag, "/R4"};
      if (rem > half || (rem == half && q[0])) q = q + 1;
      if (q >= (64'd1 << 24)) begin q = q >> 1; ee = ee + 1; tag = {tag, "/R10"}; end
      if (ee >= 255) begin
        w = {s, 8'hFF, 23'b0}; ov = 1; ix = 1; tag = {tag, "/R6"};
      end else begin
        w = {s, ee[7:0], q[22:0]}; ov = 0; ix = (rem != 0); tag = {tag, "/R2/R8"};
      end
    end
  endtask

  task automatic run_one(input logic s, input logic [7:0] e, input logic [24:0] sig,
                         input logic [2:0] grs, input logic inv);
    logic [31:0] w; logic ov, ix; string tag;
    model(s, e, sig, grs, inv, w, ov, ix, tag);
    @(negedge clk);
    in_valid = 1; in_invalid = inv; in_sign = s; in_exp = e; in_sig = sig; in_grs = grs;
    @(negedge clk);
    in_valid = 0;
    check({tag, " word"}, out_word, w);
    check({tag, " ovf"}, {31'b0, out_ovf}, {31'b0, ov});
    check({tag, " inexact"}, {31'b0, out_inexact}, {31'b0, ix});
    check("R1 valid", {31'b0, out_valid}, 32'd1);
  endtask

  initial begin
    logic [7:0] exps [6];
    logic [31:0] held;
    exps = '{8'd0, 8'd1, 8'd127, 8'd253, 8'd254, 8'd255};
    rst_n = 0; in_valid = 0; in_invalid = 0; in_sign = 0;
    in_exp = 0; in_sig = 0; in_grs = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 word", out_word, 32'h0);
    check("R11 valid", {31'b0, out_valid}, 32'h0);
    check("R11 flags", {30'b0, out_ovf, out_inexact}, 32'h0);
    rst_n = 1;
    for (int ei = 0; ei < 6; ei++)
      for (int c = 0; c < 2; c++)
        for (int h = 0; h < 2; h++)
          for (int hi = 0; hi < 2; hi++)
            for (int lo = 0; lo < 8; lo++)
              for (int g = 0; g < 8; g++) begin
                logic [24:0] sig;
                sig = {c[0], h[0], (hi != 0) ? 20'hFFFFF : 20'h0, lo[2:0]};
                run_one(lo[0] ^ g[1], exps[ei], sig, g[2:0], 1'b0);
              end
    // R7 invalid overrides everything
    run_one(1'b1, 8'd0, 25'h0, 3'b000, 1'b1);
    run_one(1'b1, 8'd254, 25'h1FFFFFF, 3'b111, 1'b1);
    run_one(1'b0, 8'd100, 25'h0ABCDEF, 3'b100, 1'b1);
    // R1 hold when enable low
    run_one(1'b1, 8'd130, 25'h0C00001, 3'b101, 1'b0);
    held = out_word;
    @(negedge clk);
    in_invalid = 1; in_exp = 8'd3; in_sig = 25'h1000000; in_grs = 3'b111;
    @(negedge clk);
    check("R1 hold word", out_word, held);
    check("R1 valid low", {31'b0, out_valid}, 32'h0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule